// File: doc/BRIEF.md
# Paged Transmit Buffer with Bit Serializer

This block holds a 256-bit transmit frame and sends it out one bit at a time. A processor fills the frame through a window of sixteen byte addresses. A page bit selects whether that window covers the lower 128 bits or the upper 128 bits of the frame. Reads from the window are combinational. A write changes one byte on the clock edge.

The serializer ignores the page bit. After a start pulse it walks the frame from bit 0 upward. Within each byte it sends the least significant bit first. Each cycle in which an external bit strobe is high produces one bit. The number of bits sent comes from a frame-length input. A busy flag covers the whole transfer, and a one-cycle done pulse closes it.

The serializer reads the storage live, so a byte that is rewritten ahead of the current bit position is sent with its new value. Frame contents have no reset. Only the control state and the page bit are reset.

Top module: `paged_txbuf`

## Requirements
- R1: While pageSel is 0, window address 0x3C+k (k = 0..15) reads and writes frame bits [8k+7:8k]. While pageSel is 1, the same address reaches bits [128+8k+7:128+8k].
- R2: pageSel is 0 after reset. It takes the value of pageVal on a clock edge where pageWr is 1, and holds its value at every other edge.
- R3: busRdata returns 0 for any address outside 0x3C..0x4B. A write to such an address changes no frame byte.
- R4: busRdata shows the addressed byte combinationally. A write with busWe high changes only the addressed byte, at that clock edge.
- R5: Asserting reset leaves every frame byte unchanged.
- R6: The n-th bit sent (n counted from 0) is frame bit n, which is bit n mod 8 of byte n/8. The order does not depend on pageSel.
- R7: A start pulse in idle raises busy at the next edge. After that, each edge with bitEn high sends one bit: txValid is 1 and txBit holds that bit in the following cycle. An edge with bitEn low leaves txValid at 0.
- R8: frameLen set to 1..255 sends exactly that many bits. frameLen set to 0 sends 256 bits. The value is taken at the start pulse.
- R9: done is high for exactly one cycle, the cycle after txValid carries the last bit. busy falls on that same edge.
- R10: A start pulse while busy is high neither restarts nor disturbs the transfer, and no new transfer follows it.
- R11: A bus write to a byte whose bits have not yet been sent changes the bits that are later sent from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of control state and page bit |
| busAddr | input | 8 | Byte address of the register window |
| busWe | input | 1 | Write enable for the addressed byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| pageWr | input | 1 | Loads the page bit |
| pageVal | input | 1 | New page bit value |
| pageSel | output | 1 | Current page bit |
| start | input | 1 | Begins a transfer when idle |
| frameLen | input | 8 | Bits to send; 0 means 256 |
| bitEn | input | 1 | Per-bit strobe |
| txBit | output | 1 | Serial data |
| txValid | output | 1 | txBit carries a bit this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The properties assume that every input is synchronous to clk and changes only between edges. The read-stability property also assumes that busRdata can change only when busAddr changes, when the page bit is loaded, or when a write occurs. The stimulus drives every input on the falling edge and keeps bus writes and page loads to single-cycle pulses. It randomizes bitEn density, frame lengths and page settings from a fixed seed. On top of that it places directed cases: a full 256-bit frame, a one-bit frame, a mid-frame rewrite of an unsent byte, and a start pulse during a transfer.

// File: rtl/paged_txbuf_pkg.sv
package paged_txbuf_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SHIFT = 2'd1,
    S_FIN   = 2'd2
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic emit;   // present bitIdx on the serial output at this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/paged_txbuf_ctrl.sv
module paged_txbuf_ctrl
  import paged_txbuf_pkg::*;
#(
  parameter int BUF_BITS = 256,
  parameter int IDX_W    = $clog2(BUF_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             bitEn,
  input  logic [IDX_W-1:0] frameLen,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = IDX_W + 1;

  ctrlState_e       state;
  logic [IDX_W-1:0] lastIdx;
  logic [CNT_W-1:0] lenEff;

  assign lenEff = (frameLen == '0) ? CNT_W'(BUF_BITS) : {1'b0, frameLen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitIdx  <= '0;
      lastIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_SHIFT;
          bitIdx  <= '0;
          lastIdx <= IDX_W'(lenEff - CNT_W'(1));
        end
        S_SHIFT: if (bitEn) begin
          if (bitIdx == lastIdx) state <= S_FIN;
          else                   bitIdx <= bitIdx + IDX_W'(1);
        end
        S_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strobe.emit = (state == S_SHIFT) && bitEn;
  assign busy        = (state != S_IDLE);

  // checker state: bits emitted against the length taken at start
  logic [CNT_W-1:0] emitCnt;
  logic [CNT_W-1:0] lenChk;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      emitCnt <= '0;
      lenChk  <= '0;
    end else if (state == S_IDLE && start) begin
      emitCnt <= '0;
      lenChk  <= lenEff;
    end else if (strobe.emit) begin
      emitCnt <= emitCnt + CNT_W'(1);
    end
  end

  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (emitCnt == lenChk));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy) && !$past(done)));

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SHIFT && start && !bitEn) |=> (busy && bitIdx == $past(bitIdx)));

  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx <= lastIdx));

endmodule

// File: rtl/paged_txbuf_dp.sv
module paged_txbuf_dp
  import paged_txbuf_pkg::*;
#(
  parameter int BUF_BITS  = 256,
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h3C,
  parameter int IDX_W     = $clog2(BUF_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              pageWr,
  input  logic              pageVal,
  output logic              pageSel,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              txBit,
  output logic              txValid
);
  localparam int NUM_BYTES  = BUF_BITS / BYTE_W;
  localparam int BYTE_IDX_W = $clog2(NUM_BYTES);
  localparam int WIN_IDX_W  = $clog2(WIN_BYTES);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE_ADDR + WIN_BYTES);

  logic                  inWin;
  logic [WIN_IDX_W-1:0]  winOff;
  logic [BYTE_IDX_W-1:0] byteSel;
  logic [BYTE_W-1:0]     bufBytes [NUM_BYTES];
  logic [BUF_BITS-1:0]   flatBuf;

  assign inWin   = ({1'b0, busAddr} >= WIN_LO) && ({1'b0, busAddr} < WIN_HI);
  assign winOff  = WIN_IDX_W'(busAddr - ADDR_W'(BASE_ADDR));
  assign byteSel = {pageSel, winOff};

  // storage without reset, one register per byte
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] byteReg;
    always_ff @(posedge clk) begin
      if (busWe && inWin && byteSel == BYTE_IDX_W'(g)) byteReg <= busWdata;
    end
    assign bufBytes[g]                  = byteReg;
    assign flatBuf[g*BYTE_W +: BYTE_W] = byteReg;
  end

  assign busRdata = inWin ? bufBytes[byteSel] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) pageSel <= 1'b0;
    else if (pageWr) pageSel <= pageVal;
  end

  // serial output reads the live buffer, never a snapshot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBit   <= 1'b0;
      txValid <= 1'b0;
    end else begin
      txValid <= strobe.emit;
      if (strobe.emit) txBit <= flatBuf[bitIdx];
    end
  end

  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pageWr) |-> $stable(pageSel));

  p_read_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busWe) && !$past(pageWr) && $stable(busAddr)) |-> $stable(busRdata));

endmodule

// File: rtl/paged_txbuf.sv
module paged_txbuf
  import paged_txbuf_pkg::*;
#(
  parameter int BUF_BITS  = 256,
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h3C,
  parameter int IDX_W     = $clog2(BUF_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              pageWr,
  input  logic              pageVal,
  output logic              pageSel,
  input  logic              start,
  input  logic [IDX_W-1:0]  frameLen,
  input  logic              bitEn,
  output logic              txBit,
  output logic              txValid,
  output logic              busy,
  output logic              done
);
  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] bitIdx;

  paged_txbuf_ctrl #(.BUF_BITS(BUF_BITS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bitEn(bitEn),
    .frameLen(frameLen), .strobe(strobe), .bitIdx(bitIdx),
    .busy(busy), .done(done)
  );

  paged_txbuf_dp #(
    .BUF_BITS(BUF_BITS), .BYTE_W(BYTE_W), .WIN_BYTES(WIN_BYTES),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pageWr(pageWr),
    .pageVal(pageVal), .pageSel(pageSel), .strobe(strobe),
    .bitIdx(bitIdx), .txBit(txBit), .txValid(txValid)
  );

  p_valid_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy);

endmodule

// File: tb/paged_txbuf_bench.sv
`timescale 1ns/1ps
module paged_txbuf_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] busAddr, busWdata, busRdata, frameLen;
  logic       busWe, pageWr, pageVal, pageSel, start, bitEn;
  logic       txBit, txValid, busy, done;

  int checks = 0;
  int errors = 0;
  logic [255:0] model;
  logic         expPage;

  always #2.5 clk = ~clk;

  paged_txbuf u_paged_txbuf (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pageWr(pageWr),
    .pageVal(pageVal), .pageSel(pageSel), .start(start),
    .frameLen(frameLen), .bitEn(bitEn), .txBit(txBit),
    .txValid(txValid), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic pg, input logic [7:0] a);
    if (a < 8'h3C || a > 8'h4B) return 8'h00;
    return model[({27'd0, pg, 4'd0} + 32'(a - 8'h3C)) * 8 +: 8];
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    if (a >= 8'h3C && a <= 8'h4B)
      model[({27'd0, expPage, 4'd0} + 32'(a - 8'h3C)) * 8 +: 8] = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busReadChk(input logic [7:0] a, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(busRdata === expRead(expPage, a), tag, 32'(busRdata), 32'(expRead(expPage, a)));
  endtask

  task automatic setPage(input logic v);
    @(negedge clk);
    pageWr = 1'b1; pageVal = v;
    @(negedge clk);
    pageWr = 1'b0;
    expPage = v;
    chk(pageSel === v, "R2 page load", 32'(pageSel), 32'(v));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expPage = 1'b0;
  endtask

  task automatic runFrame(input int len, input int enPct, input bit injWrite, input bit injStart);
    int effLen;
    int sent;
    int wrByte;
    logic [7:0] wrData;
    bit en;
    effLen = (len == 0) ? 256 : len;
    wrByte = -1;
    @(negedge clk);
    start = 1'b1; frameLen = 8'(len); bitEn = 1'b0;
    @(posedge clk); #1;
    chk(busy === 1'b1, "R7 busy after start", 32'(busy), 32'd1);
    sent = 0;
    while (sent < effLen) begin
      @(negedge clk);
      start = 1'b0; busWe = 1'b0;
      frameLen = 8'($urandom);
      en = ($urandom % 100) < enPct;
      bitEn = en;
      if (injStart && sent == effLen / 2) start = 1'b1;
      if (injWrite && sent == 8 && wrByte < 0) begin
        wrByte = {27'd0, expPage, 4'd2};
        wrData = ~model[wrByte*8 +: 8];
        busAddr = 8'h3E; busWdata = wrData; busWe = 1'b1;
        model[wrByte*8 +: 8] = wrData;
      end
      @(posedge clk); #1;
      if (en) begin
        chk(txValid === 1'b1, "R7 valid on strobe", 32'(txValid), 32'd1);
        if (wrByte >= 0 && sent / 8 == wrByte)
          chk(txBit === model[sent], "R11 rewritten bit", 32'(txBit), 32'(model[sent]));
        else
          chk(txBit === model[sent], "R6 bit order", 32'(txBit), 32'(model[sent]));
        sent++;
      end else begin
        chk(txValid === 1'b0, "R7 no valid without strobe", 32'(txValid), 32'd0);
      end
    end
    chk(done === 1'b0 && busy === 1'b1, "R9 done not with last bit", {done, busy}, 32'b01);
    @(negedge clk);
    bitEn = 1'b0; start = 1'b0; busWe = 1'b0;
    @(posedge clk); #1;
    chk(done === 1'b1 && busy === 1'b0 && txValid === 1'b0, "R9 done pulse after last bit",
        {done, busy, txValid}, 32'b100);
    chk(sent === effLen, "R8 frame length", 32'(sent), 32'(effLen));
    @(posedge clk); #1;
    chk(done === 1'b0 && busy === 1'b0, "R10 no restart, done one cycle", {done, busy}, 32'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1717));
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0;
    pageWr = 1'b0; pageVal = 1'b0; start = 1'b0; frameLen = '0; bitEn = 1'b0;
    model = '0; expPage = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(pageSel === 1'b0, "R2 page reset", 32'(pageSel), 32'd0);
    chk({busy, done, txValid} === 3'b000, "R7 idle after reset", {busy, done, txValid}, 32'd0);

    // R1/R4: fill both pages through the window, read everything back
    for (int p = 0; p < 2; p++) begin
      setPage(p[0]);
      for (int k = 0; k < 16; k++) busWrite(8'h3C + 8'(k), 8'($urandom));
    end
    for (int p = 0; p < 2; p++) begin
      setPage(p[0]);
      for (int k = 0; k < 16; k++) busReadChk(8'h3C + 8'(k), "R1 window readback");
    end
    // R4: single byte write leaves neighbours intact
    setPage(1'b0);
    busWrite(8'h44, 8'hA5);
    busReadChk(8'h43, "R4 neighbour below");
    busReadChk(8'h44, "R4 written byte");
    busReadChk(8'h45, "R4 neighbour above");
    setPage(1'b1);
    busReadChk(8'h44, "R1 other page untouched");

    // R3: outside the window
    busReadChk(8'h3B, "R3 below window");
    busReadChk(8'h4C, "R3 above window");
    busWrite(8'h3B, 8'hFF);
    busWrite(8'h4C, 8'hFF);
    busWrite(8'h00, 8'hFF);
    for (int p = 0; p < 2; p++) begin
      setPage(p[0]);
      for (int k = 0; k < 16; k++) busReadChk(8'h3C + 8'(k), "R3 window unchanged");
    end

    // R5: reset keeps contents, page returns to 0
    setPage(1'b1);
    doReset();
    #1;
    chk(pageSel === 1'b0, "R2 page cleared by reset", 32'(pageSel), 32'd0);
    for (int p = 0; p < 2; p++) begin
      setPage(p[0]);
      for (int k = 0; k < 16; k++) busReadChk(8'h3C + 8'(k), "R5 content kept over reset");
    end

    // serial frames
    setPage(1'b1);
    runFrame(0, 100, 1'b0, 1'b0);   // R8 zero means 256, R6 page ignored
    setPage(1'b0);
    runFrame(0, 60, 1'b0, 1'b0);
    runFrame(1, 100, 1'b0, 1'b0);   // R8 single bit
    runFrame(37, 50, 1'b1, 1'b1);   // R11 live rewrite, R10 start ignored
    setPage(1'b1);
    runFrame(255, 70, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      setPage(1'($urandom));
      runFrame(int'($urandom % 256), 30 + int'($urandom % 70), 1'($urandom), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule